// File: doc/BRIEF.md
# Dual-Input Supply Qualifier

This block decides which of two external supplies may be used: an adapter input and a USB input. On every clock it takes unsigned millivolt samples of both inputs, the battery and the USB bypass output. Each input is tracked by its own small state machine. The machine applies a power-on window with hysteresis and an overvoltage window with its own hysteresis. An overvoltage only takes effect once it has lasted a programmable number of consecutive samples. Alongside the state machine, a headroom flag with hysteresis records whether the input stands far enough above the battery to charge from it.

From these per-input results the block chooses the charging source, with the adapter taking priority. It also drives four outputs: an active-low power-present indicator, an enable for a small regulator fed from the adapter, an enable for the USB bypass switch, and a three-valued status per input. Every output is registered through the per-input state, so a new sample shows at the outputs after one clock edge.

Per-input states: `MS_OFF` (below power-on), `MS_ON` (good), `MS_OVPEND` (above the overvoltage level, still counting, still reported good) and `MS_OVLOCK` (overvoltage in effect). The transitions are:
- `MS_OFF`→`MS_ON` when the sample rises above the power-on level.
- `MS_OFF`/`MS_ON`→`MS_OVPEND` when the sample exceeds the overvoltage level. The jump goes straight to `MS_OVLOCK` when the delay is 0 or 1.
- `MS_ON`→`MS_OFF` when the sample falls below the power-off level.
- `MS_OVPEND`→`MS_OVLOCK` when the count of consecutive samples above the level reaches the delay.
- `MS_OVPEND`→`MS_ON` (or `MS_OFF`) when the sample drops back to or below the overvoltage level.
- `MS_OVLOCK`→`MS_ON` (or `MS_OFF`) when the sample falls below the release level.

Top module: `supply_qualifier`

## Requirements
- R1: An input's power-on condition is set when its sample exceeds 3900 mV and is cleared only when the sample falls below 3700 mV. The comparisons are strict, so exactly 3900 does not set it and exactly 3700 does not clear it.
- R2: The adapter input enters overvoltage when its sample exceeds 6800 mV (strict). It leaves overvoltage only once the sample is below 6710 mV, so 6710 stays in overvoltage.
- R3: The USB input enters overvoltage when its sample exceeds 5400 mV. It leaves overvoltage only once the sample is below 5340 mV.
- R4: Overvoltage takes effect only after `ov_delay` consecutive samples above the level, with a value of 0 treated as 1. A shorter excursion leaves the input reported good.
- R5: An input's headroom flag sets when the input minus the battery exceeds 150 mV. It clears only when that difference falls below 80 mV.
- R6: `src_sel` is 1 (adapter) when the adapter is good and has headroom. Otherwise it is 2 (USB) when USB is good and has headroom. Otherwise it is 0 (none). The value 3 never occurs.
- R7: `present_n` is 0 while at least one input is good. It is 1 when no input is good, including when every input is in overvoltage.
- R8: `ldo_en` is 1 exactly when the adapter is good. `byp_en` is 1 when USB is good and the bypass is not reverse-driven. Neither output depends on headroom.
- R9: `byp_en` is 0 in the cycle after a sample in which `byp_mv` exceeds `usb_mv` (strict; equal values do not force it off).
- R10: `adp_stat` and `usb_stat` report 0 for below power-on, 1 for good (including an overvoltage still being counted) and 2 for overvoltage in effect.
- R11: While `rst_n` is low, the outputs are: `present_n`=1, `src_sel`=0, `ldo_en`=0, `byp_en`=0 and both statuses 0, whatever the input samples are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adp_mv | input | MV_W | Adapter input sample, mV |
| usb_mv | input | MV_W | USB input sample, mV |
| bat_mv | input | MV_W | Battery sample, mV |
| byp_mv | input | MV_W | USB bypass output sample, mV |
| ov_delay | input | DLY_W | Overvoltage qualification length in samples |
| present_n | output | 1 | Active-low power-present indicator |
| src_sel | output | 2 | Selected source: 0 none, 1 adapter, 2 USB |
| ldo_en | output | 1 | Regulator enable |
| byp_en | output | 1 | USB bypass switch enable |
| adp_stat | output | 2 | Adapter status: 0 below, 1 good, 2 overvoltage |
| usb_stat | output | 2 | USB status: 0 below, 1 good, 2 overvoltage |

## Verification
The hardest cases to reach from the ports depend on history. These are an input held inside a hysteresis band, a headroom difference between 80 and 150 mV, and an overvoltage excursion one sample shorter than the delay. In each of these the right answer depends on earlier samples, not on the present one. The stimulus table therefore walks one continuous sequence that first enters each band from one side and then sits inside it. Directed sequences then set `ov_delay` to 4 and apply three samples above the level, one below and three more above. This shows that the count restarts. A fourth consecutive sample then finally moves the input into overvoltage.

// File: rtl/qual_pkg.sv
package qual_pkg;

    // Per-input status as seen at the ports
    typedef enum logic [1:0] {
        ST_BELOW = 2'd0,
        ST_GOOD  = 2'd1,
        ST_OVER  = 2'd2
    } in_stat_t;

    // Selected charging source
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ADP  = 2'd1,
        SEL_USB  = 2'd2
    } src_t;

    // Per-input qualification machine
    typedef enum logic [1:0] {
        MS_OFF    = 2'd0,
        MS_ON     = 2'd1,
        MS_OVPEND = 2'd2,
        MS_OVLOCK = 2'd3
    } mon_state_t;

endpackage

// File: rtl/input_monitor.sv
module input_monitor
    import qual_pkg::*;
#(
    parameter int MV_W        = 16,
    parameter int DLY_W       = 8,
    parameter int PON_RISE_MV = 3900,
    parameter int PON_FALL_MV = 3700,
    parameter int OV_MV       = 6800,
    parameter int OV_HYST_MV  = 90,
    parameter int HR_RISE_MV  = 150,
    parameter int HR_FALL_MV  = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MV_W-1:0]  vin,
    input  logic [MV_W-1:0]  vbat,
    input  logic [DLY_W-1:0] ov_delay,
    output logic [1:0]       stat,
    output logic             headroom_ok
);

    localparam logic [MV_W-1:0] ON_V   = MV_W'(PON_RISE_MV);
    localparam logic [MV_W-1:0] OFF_V  = MV_W'(PON_FALL_MV);
    localparam logic [MV_W-1:0] OV_V   = MV_W'(OV_MV);
    localparam logic [MV_W-1:0] REL_V  = MV_W'(OV_MV - OV_HYST_MV);
    localparam logic signed [MV_W:0] HR_SET = (MV_W+1)'(HR_RISE_MV);
    localparam logic signed [MV_W:0] HR_CLR = (MV_W+1)'(HR_FALL_MV);

    mon_state_t st, st_nx;
    logic [DLY_W-1:0] cnt, cnt_nx;
    logic [DLY_W:0]   cnt_inc;
    logic on_rise, on_fall, ov_hi, ov_rel, instant, reached;
    logic signed [MV_W:0] diff;

    assign on_rise = vin > ON_V;
    assign on_fall = vin < OFF_V;
    assign ov_hi   = vin > OV_V;
    assign ov_rel  = vin < REL_V;
    assign instant = ov_delay <= DLY_W'(1);
    assign cnt_inc = {1'b0, cnt} + (DLY_W+1)'(1);
    assign reached = cnt_inc >= {1'b0, ov_delay};
    assign diff    = $signed({1'b0, vin}) - $signed({1'b0, vbat});

    // State register, counter and headroom flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= MS_OFF;
            cnt         <= '0;
            headroom_ok <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            if (diff > HR_SET)
                headroom_ok <= 1'b1;
            else if (diff < HR_CLR)
                headroom_ok <= 1'b0;
        end
    end

    // Next state
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            MS_OFF, MS_ON: begin
                if ((st == MS_ON || on_rise) && ov_hi) begin
                    if (instant) begin
                        st_nx = MS_OVLOCK;
                    end else begin
                        st_nx  = MS_OVPEND;
                        cnt_nx = DLY_W'(1);
                    end
                end else if (st == MS_OFF && on_rise) begin
                    st_nx = MS_ON;
                end else if (st == MS_ON && on_fall) begin
                    st_nx = MS_OFF;
                end
            end
            MS_OVPEND: begin
                if (!ov_hi) begin
                    st_nx  = on_fall ? MS_OFF : MS_ON;
                    cnt_nx = '0;
                end else if (reached) begin
                    st_nx  = MS_OVLOCK;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt_inc[DLY_W-1:0];
                end
            end
            MS_OVLOCK: begin
                if (ov_rel)
                    st_nx = on_fall ? MS_OFF : MS_ON;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (st)
            MS_OFF:           stat = ST_BELOW;
            MS_ON, MS_OVPEND: stat = ST_GOOD;
            MS_OVLOCK:        stat = ST_OVER;
        endcase
    end

endmodule

// File: rtl/source_arbiter.sv
module source_arbiter
    import qual_pkg::*;
#(
    parameter int MV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      adp_stat,
    input  logic [1:0]      usb_stat,
    input  logic            adp_hr,
    input  logic            usb_hr,
    input  logic [MV_W-1:0] usb_mv,
    input  logic [MV_W-1:0] byp_mv,
    output logic            present_n,
    output logic [1:0]      src_sel,
    output logic            ldo_en,
    output logic            byp_en
);

    logic rev_drive;
    logic adp_ok, usb_ok;

    always_ff @(posedge clk) begin
        if (!rst_n)
            rev_drive <= 1'b0;
        else
            rev_drive <= byp_mv > usb_mv;
    end

    assign adp_ok = adp_stat == ST_GOOD;
    assign usb_ok = usb_stat == ST_GOOD;

    always_comb begin
        present_n = !(adp_ok || usb_ok);
        ldo_en    = adp_ok;
        byp_en    = usb_ok && !rev_drive;
        if (adp_ok && adp_hr)
            src_sel = SEL_ADP;
        else if (usb_ok && usb_hr)
            src_sel = SEL_USB;
        else
            src_sel = SEL_NONE;
    end

endmodule

// File: rtl/supply_qualifier.sv
module supply_qualifier
    import qual_pkg::*;
#(
    parameter int MV_W           = 16,
    parameter int DLY_W          = 8,
    parameter int PON_RISE_MV    = 3900,
    parameter int PON_FALL_MV    = 3700,
    parameter int ADP_OV_MV      = 6800,
    parameter int ADP_OV_HYST_MV = 90,
    parameter int USB_OV_MV      = 5400,
    parameter int USB_OV_HYST_MV = 60,
    parameter int HR_RISE_MV     = 150,
    parameter int HR_FALL_MV     = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MV_W-1:0]  adp_mv,
    input  logic [MV_W-1:0]  usb_mv,
    input  logic [MV_W-1:0]  bat_mv,
    input  logic [MV_W-1:0]  byp_mv,
    input  logic [DLY_W-1:0] ov_delay,
    output logic             present_n,
    output logic [1:0]       src_sel,
    output logic             ldo_en,
    output logic             byp_en,
    output logic [1:0]       adp_stat,
    output logic [1:0]       usb_stat
);

    localparam int N_IN = 2;   // channel 0 adapter, channel 1 USB

    logic [MV_W-1:0] ch_v    [N_IN];
    logic [1:0]      ch_stat [N_IN];
    logic            ch_hr   [N_IN];

    assign ch_v[0] = adp_mv;
    assign ch_v[1] = usb_mv;

    for (genvar g = 0; g < N_IN; g++) begin : g_ch
        input_monitor #(
            .MV_W       (MV_W),
            .DLY_W      (DLY_W),
            .PON_RISE_MV(PON_RISE_MV),
            .PON_FALL_MV(PON_FALL_MV),
            .OV_MV      (g == 0 ? ADP_OV_MV : USB_OV_MV),
            .OV_HYST_MV (g == 0 ? ADP_OV_HYST_MV : USB_OV_HYST_MV),
            .HR_RISE_MV (HR_RISE_MV),
            .HR_FALL_MV (HR_FALL_MV)
        ) u_mon (
            .clk        (clk),
            .rst_n      (rst_n),
            .vin        (ch_v[g]),
            .vbat       (bat_mv),
            .ov_delay   (ov_delay),
            .stat       (ch_stat[g]),
            .headroom_ok(ch_hr[g])
        );
    end

    assign adp_stat = ch_stat[0];
    assign usb_stat = ch_stat[1];

    source_arbiter #(.MV_W(MV_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .adp_stat (ch_stat[0]),
        .usb_stat (ch_stat[1]),
        .adp_hr   (ch_hr[0]),
        .usb_hr   (ch_hr[1]),
        .usb_mv   (usb_mv),
        .byp_mv   (byp_mv),
        .present_n(present_n),
        .src_sel  (src_sel),
        .ldo_en   (ldo_en),
        .byp_en   (byp_en)
    );

endmodule

// File: rtl/supply_qualifier_chk.sv
module supply_qualifier_chk #(
    parameter int MV_W           = 16,
    parameter int PON_RISE_MV    = 3900,
    parameter int ADP_OV_MV      = 6800,
    parameter int ADP_OV_HYST_MV = 90,
    parameter int USB_OV_MV      = 5400,
    parameter int USB_OV_HYST_MV = 60
) (
    input logic            clk,
    input logic            rst_n,
    input logic [MV_W-1:0] adp_mv,
    input logic [MV_W-1:0] usb_mv,
    input logic [MV_W-1:0] byp_mv,
    input logic            present_n,
    input logic [1:0]      src_sel,
    input logic            ldo_en,
    input logic            byp_en,
    input logic [1:0]      adp_stat,
    input logic [1:0]      usb_stat
);

    localparam logic [MV_W-1:0] ON_V    = MV_W'(PON_RISE_MV);
    localparam logic [MV_W-1:0] AOV_V   = MV_W'(ADP_OV_MV);
    localparam logic [MV_W-1:0] AREL_V  = MV_W'(ADP_OV_MV - ADP_OV_HYST_MV);
    localparam logic [MV_W-1:0] UOV_V   = MV_W'(USB_OV_MV);
    localparam logic [MV_W-1:0] UREL_V  = MV_W'(USB_OV_MV - USB_OV_HYST_MV);

    assert_pon_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(adp_stat) == 2'd0 && adp_stat != 2'd0) |-> $past(adp_mv) > ON_V);

    assert_adp_ov_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adp_stat == 2'd2) |-> $past(adp_mv) > AOV_V);

    assert_adp_ov_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adp_stat == 2'd2) |-> $past(adp_mv) < AREL_V);

    assert_usb_ov_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usb_stat == 2'd2) |-> $past(usb_mv) > UOV_V);

    assert_usb_ov_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(usb_stat == 2'd2) |-> $past(usb_mv) < UREL_V);

    assert_src_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd1 |-> adp_stat == 2'd1) and (src_sel == 2'd2 |-> usb_stat == 2'd1)
        and (src_sel != 2'd3));

    assert_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adp_stat == 2'd2 && usb_stat == 2'd2) |-> present_n);

    assert_ldo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ldo_en |-> adp_stat == 2'd1);

    assert_byp_reverse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(byp_mv) > $past(usb_mv)) |-> !byp_en);

endmodule

bind supply_qualifier supply_qualifier_chk #(
    .MV_W          (MV_W),
    .PON_RISE_MV   (PON_RISE_MV),
    .ADP_OV_MV     (ADP_OV_MV),
    .ADP_OV_HYST_MV(ADP_OV_HYST_MV),
    .USB_OV_MV     (USB_OV_MV),
    .USB_OV_HYST_MV(USB_OV_HYST_MV)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adp_mv   (adp_mv),
    .usb_mv   (usb_mv),
    .byp_mv   (byp_mv),
    .present_n(present_n),
    .src_sel  (src_sel),
    .ldo_en   (ldo_en),
    .byp_en   (byp_en),
    .adp_stat (adp_stat),
    .usb_stat (usb_stat)
);

// File: tb/supply_qualifier_tb.sv
module supply_qualifier_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] adp_mv = '0, usb_mv = '0, bat_mv = '0, byp_mv = '0;
    logic [7:0]  ov_delay = 8'd1;
    logic        present_n, ldo_en, byp_en;
    logic [1:0]  src_sel, adp_stat, usb_stat;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    supply_qualifier u_dut (
        .clk(clk), .rst_n(rst_n), .adp_mv(adp_mv), .usb_mv(usb_mv),
        .bat_mv(bat_mv), .byp_mv(byp_mv), .ov_delay(ov_delay),
        .present_n(present_n), .src_sel(src_sel), .ldo_en(ldo_en),
        .byp_en(byp_en), .adp_stat(adp_stat), .usb_stat(usb_stat)
    );

    // {adp, usb, bat, byp, present_n, src, ldo, byp_en, adp_stat, usb_stat}
    localparam int ROWS = 21;
    localparam logic [72:0] TBL [ROWS] = '{
        {16'd0,    16'd0,    16'd3600, 16'd0,    1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0}, // idle
        {16'd3850, 16'd0,    16'd3600, 16'd0,    1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 below rise
        {16'd5000, 16'd0,    16'd3600, 16'd0,    1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 2'd0}, // R1 on
        {16'd3800, 16'd0,    16'd3600, 16'd0,    1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 2'd0}, // R1 band
        {16'd3650, 16'd0,    16'd3600, 16'd0,    1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 off
        {16'd0,    16'd5000, 16'd3600, 16'd0,    1'b0, 2'd2, 1'b0, 1'b1, 2'd0, 2'd1}, // USB only
        {16'd5000, 16'd5000, 16'd3600, 16'd0,    1'b0, 2'd1, 1'b1, 1'b1, 2'd1, 2'd1}, // R6 priority
        {16'd6850, 16'd5000, 16'd3600, 16'd0,    1'b0, 2'd2, 1'b0, 1'b1, 2'd2, 2'd1}, // R2 over
        {16'd6750, 16'd5000, 16'd3600, 16'd0,    1'b0, 2'd2, 1'b0, 1'b1, 2'd2, 2'd1}, // R2 band
        {16'd6700, 16'd5000, 16'd3600, 16'd0,    1'b0, 2'd1, 1'b1, 1'b1, 2'd1, 2'd1}, // R2 release
        {16'd6700, 16'd5450, 16'd3600, 16'd0,    1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 2'd2}, // R3 over
        {16'd6700, 16'd5350, 16'd3600, 16'd0,    1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 2'd2}, // R3 band
        {16'd7000, 16'd5450, 16'd3600, 16'd0,    1'b1, 2'd0, 1'b0, 1'b0, 2'd2, 2'd2}, // R7 both over
        {16'd5000, 16'd5300, 16'd3600, 16'd0,    1'b0, 2'd1, 1'b1, 1'b1, 2'd1, 2'd1}, // recover
        {16'd5000, 16'd5000, 16'd4900, 16'd0,    1'b0, 2'd1, 1'b1, 1'b1, 2'd1, 2'd1}, // R5 hold
        {16'd5000, 16'd5000, 16'd4950, 16'd0,    1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 2'd1}, // R5 clear
        {16'd5000, 16'd5000, 16'd4900, 16'd0,    1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 2'd1}, // R5 stay clear
        {16'd5000, 16'd5000, 16'd4840, 16'd0,    1'b0, 2'd1, 1'b1, 1'b1, 2'd1, 2'd1}, // R5 set
        {16'd5000, 16'd5000, 16'd4840, 16'd5100, 1'b0, 2'd1, 1'b1, 1'b0, 2'd1, 2'd1}, // R9 reverse
        {16'd5000, 16'd5000, 16'd4840, 16'd5000, 1'b0, 2'd1, 1'b1, 1'b1, 2'd1, 2'd1}, // R9 equal
        {16'd0,    16'd5000, 16'd4840, 16'd5000, 1'b0, 2'd2, 1'b0, 1'b1, 2'd0, 2'd1}  // R6 fallback
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        // R11: reset state with live inputs
        @(negedge clk);
        adp_mv = 16'd5000; usb_mv = 16'd5000; bat_mv = 16'd3600; byp_mv = 16'd0;
        rst_n = 1'b0;
        repeat (3) step();
        chk("R11", "present_n", present_n, 1);
        chk("R11", "src_sel", src_sel, 0);
        chk("R11", "ldo_en", ldo_en, 0);
        chk("R11", "byp_en", byp_en, 0);
        chk("R11", "adp_stat", adp_stat, 0);
        chk("R11", "usb_stat", usb_stat, 0);
        rst_n = 1'b1;
        adp_mv = 16'd0; usb_mv = 16'd0;

        // Table walk, ov_delay = 1
        for (int i = 0; i < ROWS; i++) begin
            adp_mv = TBL[i][72:57];
            usb_mv = TBL[i][56:41];
            bat_mv = TBL[i][40:25];
            byp_mv = TBL[i][24:9];
            step();
            chk("R7", "present_n", present_n, int'(TBL[i][8]));
            chk("R6", "src_sel", src_sel, int'(TBL[i][7:6]));
            chk("R8", "ldo_en", ldo_en, int'(TBL[i][5]));
            chk("R8", "byp_en", byp_en, int'(TBL[i][4]));
            chk("R10", "adp_stat", adp_stat, int'(TBL[i][3:2]));
            chk("R10", "usb_stat", usb_stat, int'(TBL[i][1:0]));
        end

        // R1 exact edges
        do_reset();
        bat_mv = 16'd3600; byp_mv = 16'd0; usb_mv = 16'd0;
        adp_mv = 16'd3900; step(); chk("R1", "adp_stat at 3900", adp_stat, 0);
        adp_mv = 16'd3901; step(); chk("R1", "adp_stat at 3901", adp_stat, 1);
        adp_mv = 16'd3700; step(); chk("R1", "adp_stat at 3700", adp_stat, 1);
        adp_mv = 16'd3699; step(); chk("R1", "adp_stat at 3699", adp_stat, 0);

        // R2 exact edges
        adp_mv = 16'd5000; step();
        adp_mv = 16'd6800; step(); chk("R2", "adp_stat at 6800", adp_stat, 1);
        adp_mv = 16'd6801; step(); chk("R2", "adp_stat at 6801", adp_stat, 2);
        adp_mv = 16'd6710; step(); chk("R2", "adp_stat at 6710", adp_stat, 2);
        adp_mv = 16'd6709; step(); chk("R2", "adp_stat at 6709", adp_stat, 1);

        // R3 exact edges
        usb_mv = 16'd5400; step(); chk("R3", "usb_stat at 5400", usb_stat, 1);
        usb_mv = 16'd5401; step(); chk("R3", "usb_stat at 5401", usb_stat, 2);
        usb_mv = 16'd5340; step(); chk("R3", "usb_stat at 5340", usb_stat, 2);
        usb_mv = 16'd5339; step(); chk("R3", "usb_stat at 5339", usb_stat, 1);

        // R4 delay of 4 samples
        ov_delay = 8'd4;
        usb_mv = 16'd5000; step();
        usb_mv = 16'd5500;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R4", "usb_stat while counting", usb_stat, 1);
            chk("R4", "byp_en while counting", byp_en, 1);
        end
        step(); chk("R4", "usb_stat after 4 samples", usb_stat, 2);
        usb_mv = 16'd5000; step(); chk("R4", "usb_stat recovered", usb_stat, 1);

        // R4 short excursions separated by one low sample
        for (int k = 0; k < 3; k++) begin usb_mv = 16'd5500; step(); end
        usb_mv = 16'd5000; step();
        for (int k = 0; k < 3; k++) begin usb_mv = 16'd5500; step(); end
        chk("R4", "usb_stat after split excursion", usb_stat, 1);
        step(); chk("R4", "usb_stat fourth consecutive", usb_stat, 2);

        // R4 zero delay acts as one
        ov_delay = 8'd0;
        usb_mv = 16'd5000; step();
        usb_mv = 16'd5500; step(); chk("R4", "usb_stat with delay 0", usb_stat, 2);

        summary();
        $finish;
    end

endmodule